// File: doc/BRIEF.md
# Superscalar Decode Stage Controller with Bundle Replay Queue

The block sits between instruction fetch and register rename. Every cycle fetch may present a bundle of up to `W` abstract instruction records, each carrying a sequence number, a PC, a predicted next PC, a branch target and a handful of flags. The stage passes the live records on to rename, packed into the lowest lanes. While it passes them on, it resolves direct unconditional branches: it replaces the next PC with the target and sends fetch a redirect as soon as a prediction proves wrong.

Downstream stages can hold the stage back with three stall inputs: rename, execute and commit. Commit can also order a squash. A stall parks the whole fetch bundle in a small replay queue. While the stage is held, every further non-empty bundle joins the same queue. Once the stalls clear, the parked bundles are drained oldest first, one per cycle, and fetch stays stalled until the queue is empty. A squash empties the queue and drops work until commit releases it. All outputs are registered, so results appear on the cycle after the inputs that caused them.

Top module: `decode_stage`

## Requirements
- R1: After synchronous reset, `rn_vld`, `fe_stall` and `fe_redir` are all low, and a bundle presented in the first cycle after reset is forwarded on the next cycle.
- R2: When `cm_squash` is high in a cycle where the stage would process work, nothing is forwarded, the replay queue is emptied and the stage enters its squashing state. This takes precedence over all stall inputs.
- R3: When any of `rn_stall`, `ex_stall` or `cm_stall` is high in a processing cycle, nothing is forwarded, the current fetch bundle is kept in the replay queue and the stage becomes blocked.
- R4: While blocked, `fe_stall` is high, nothing is forwarded, and every fetch bundle with at least one valid slot is appended to the replay queue.
- R5: When all three stalls are low in a blocked cycle, the stage moves to unblocking and `fe_stall` stays high. If the queue is empty and no bundle arrives in that cycle, the stage returns straight to running with `fe_stall` low.
- R6: While unblocking, the stage processes the oldest queued bundle instead of the fetch input and removes it. A non-empty fetch bundle arriving in the same cycle is appended to the queue. `fe_stall` drops in the cycle the last queued bundle is processed.
- R7: In the squashing state, fetch input is ignored and nothing is forwarded. The stage returns to running in a cycle where `cm_squash` and `cm_rob_flush` are both low. Either of those signals in a blocked cycle also enters squashing and discards the queued bundles.
- R8: Records with `fb_vld` high and `fb_kill` low are forwarded in slot order into consecutive lanes starting at lane 0. Records marked killed are skipped. Lane i of each flat bus occupies bits `[i*SEQ_W +: SEQ_W]` for sequence numbers and `[i*PC_W +: PC_W]` for PCs, for both input and output.
- R9: A forwarded record with `fb_nosrc` set has its `rn_rdy` lane bit set. Otherwise the bit is clear.
- R10: A forwarded record with `fb_dub` set (direct unconditional branch) carries its target as next PC. Every other record carries PC + 4.
- R11: A direct unconditional branch whose predicted next PC differs from its target is forwarded itself and raises `fe_redir` with `fe_redir_ctrl` = 0, its sequence number and the target as new PC. Later slots of the bundle are dropped and the stage enters squashing.
- R12: A record predicted taken but not a control instruction is forwarded and raises `fe_redir` with `fe_redir_ctrl` = 1, its sequence number and PC + 4 as new PC. Later slots are dropped and the stage enters squashing.
- R13: The replay queue holds `SKID_DEPTH` bundles. A push into a full queue without a simultaneous pop is a usage error and is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_vld | input | W | Slot valid per fetch slot |
| fb_kill | input | W | Slot already squashed |
| fb_ptaken | input | W | Slot predicted taken |
| fb_ctrl | input | W | Slot is a control instruction |
| fb_dub | input | W | Slot is a direct unconditional branch |
| fb_nosrc | input | W | Slot has no source registers |
| fb_seq | input | W*SEQ_W | Sequence numbers |
| fb_pc | input | W*PC_W | Instruction PCs |
| fb_pnpc | input | W*PC_W | Predicted next PCs |
| fb_tgt | input | W*PC_W | Branch targets |
| rn_stall | input | 1 | Stall from rename |
| ex_stall | input | 1 | Stall from execute |
| cm_stall | input | 1 | Stall from commit |
| cm_squash | input | 1 | Squash order from commit |
| cm_rob_flush | input | 1 | Reorder buffer squashing in progress |
| rn_vld | output | W | Lane valid towards rename |
| rn_rdy | output | W | Lane ready to issue (no sources) |
| rn_seq | output | W*SEQ_W | Lane sequence numbers |
| rn_pc | output | W*PC_W | Lane PCs |
| rn_npc | output | W*PC_W | Lane resolved next PCs |
| fe_stall | output | 1 | Stall to fetch |
| fe_redir | output | 1 | Redirect to fetch (taken) |
| fe_redir_ctrl | output | 1 | Redirect caused by a false control prediction |
| fe_redir_seq | output | SEQ_W | Sequence number of the offending record |
| fe_redir_npc | output | PC_W | New fetch PC |

## Verification
Assertions check several properties on every cycle: a squash order always empties the rename lanes on the next cycle, the blocked and squashing states never forward, the blocked state always drives the fetch stall, a redirect always coincides with the squashing state, the unblocking state never runs on an empty queue, and the queue never overflows. Only the bench scenarios can show what the stage forwards and in what order. This covers lane compaction across every combination of valid and killed slots, the ready and next-PC values, the oldest-first replay order across a block and unblock sequence with bundles appended mid-drain, and the exact cycle the fetch stall drops. It also covers the redirect payloads, and that a squash discards parked bundles, so a later unblock does not replay them.

// File: rtl/dec_pkg.sv
package dec_pkg;

    parameter int W          = 4;
    parameter int SEQ_W      = 8;
    parameter int PC_W       = 16;
    parameter int INST_BYTES = 4;
    localparam int LANE_W    = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic             vld;
        logic             kill;
        logic             ptaken;
        logic             ctrl;
        logic             dub;
        logic             nosrc;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  pnpc;
        logic [PC_W-1:0]  tgt;
    } rec_t;

    typedef rec_t [W-1:0] bundle_t;

    typedef struct packed {
        logic             vld;
        logic             rdy;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  npc;
    } lane_t;

    typedef lane_t [W-1:0] lanes_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_BLK,
        ST_UNBLK,
        ST_SQ
    } dstate_e;

    function automatic logic [PC_W-1:0] fall_through(input logic [PC_W-1:0] pc);
        return pc + PC_W'(INST_BYTES);
    endfunction

    function automatic logic has_live(input bundle_t b);
        logic any;
        any = 1'b0;
        for (int i = 0; i < W; i++) any = any | b[i].vld;
        return any;
    endfunction

endpackage

// File: rtl/dec_skid_fifo.sv
module dec_skid_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          clear,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic          last
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_pop, do_push;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign last    = (cnt == CNT_W'(1));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clear) mem[wr_ptr] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !(push && !clear && full && !pop)); // R13

    AST_POP_NONEMPTY_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (do_pop && do_push && !clear) |=> (cnt == $past(cnt))); // R6

endmodule

// File: rtl/dec_slot_proc.sv
module dec_slot_proc
    import dec_pkg::*;
(
    input  logic             en,
    input  bundle_t          bin,
    output lanes_t           lanes,
    output logic             redir,
    output logic             redir_ctrl,
    output logic [SEQ_W-1:0] redir_seq,
    output logic [PC_W-1:0]  redir_npc
);
    logic              stop;
    logic [LANE_W-1:0] lane;
    logic [PC_W-1:0]   nxt;

    always_comb begin
        lanes      = '0;
        redir      = 1'b0;
        redir_ctrl = 1'b0;
        redir_seq  = '0;
        redir_npc  = '0;
        stop       = 1'b0;
        lane       = '0;
        nxt        = '0;
        for (int i = 0; i < W; i++) begin
            if (en && !stop && bin[i].vld && !bin[i].kill) begin
                nxt = bin[i].dub ? bin[i].tgt : fall_through(bin[i].pc);
                lanes[lane].vld = 1'b1;
                lanes[lane].rdy = bin[i].nosrc;
                lanes[lane].seq = bin[i].seq;
                lanes[lane].pc  = bin[i].pc;
                lanes[lane].npc = nxt;
                lane = lane + 1'b1;
                if (bin[i].ptaken && !bin[i].ctrl) begin
                    redir      = 1'b1;
                    redir_ctrl = 1'b1;
                    redir_seq  = bin[i].seq;
                    redir_npc  = fall_through(bin[i].pc);
                    stop       = 1'b1;
                end else if (bin[i].dub && (bin[i].pnpc != bin[i].tgt)) begin
                    redir      = 1'b1;
                    redir_seq  = bin[i].seq;
                    redir_npc  = bin[i].tgt;
                    stop       = 1'b1;
                end
            end
        end
    end

    always_comb begin
        AST_IDLE_NO_REDIR: assert (en || !redir); // R11
    end

endmodule

// File: rtl/decode_stage.sv
module decode_stage
    import dec_pkg::*;
#(
    parameter int SKID_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        fb_vld,
    input  logic [W-1:0]        fb_kill,
    input  logic [W-1:0]        fb_ptaken,
    input  logic [W-1:0]        fb_ctrl,
    input  logic [W-1:0]        fb_dub,
    input  logic [W-1:0]        fb_nosrc,
    input  logic [W*SEQ_W-1:0]  fb_seq,
    input  logic [W*PC_W-1:0]   fb_pc,
    input  logic [W*PC_W-1:0]   fb_pnpc,
    input  logic [W*PC_W-1:0]   fb_tgt,
    input  logic                rn_stall,
    input  logic                ex_stall,
    input  logic                cm_stall,
    input  logic                cm_squash,
    input  logic                cm_rob_flush,
    output logic [W-1:0]        rn_vld,
    output logic [W-1:0]        rn_rdy,
    output logic [W*SEQ_W-1:0]  rn_seq,
    output logic [W*PC_W-1:0]   rn_pc,
    output logic [W*PC_W-1:0]   rn_npc,
    output logic                fe_stall,
    output logic                fe_redir,
    output logic                fe_redir_ctrl,
    output logic [SEQ_W-1:0]    fe_redir_seq,
    output logic [PC_W-1:0]     fe_redir_npc
);
    localparam int BW = $bits(bundle_t);

    dstate_e         st, nst;
    bundle_t         fbun, skid_head, src;
    logic [BW-1:0]   skid_head_raw;
    logic            skid_empty, skid_full, skid_last;
    logic            push, pop, clr;
    logic            any_stall, f_live, proc_en, processing;
    lanes_t          lanes, lanes_q;
    logic            p_redir, p_ctrl;
    logic [SEQ_W-1:0] p_seq;
    logic [PC_W-1:0]  p_npc;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            fbun[i].vld    = fb_vld[i];
            fbun[i].kill   = fb_kill[i];
            fbun[i].ptaken = fb_ptaken[i];
            fbun[i].ctrl   = fb_ctrl[i];
            fbun[i].dub    = fb_dub[i];
            fbun[i].nosrc  = fb_nosrc[i];
            fbun[i].seq    = fb_seq[i*SEQ_W +: SEQ_W];
            fbun[i].pc     = fb_pc[i*PC_W +: PC_W];
            fbun[i].pnpc   = fb_pnpc[i*PC_W +: PC_W];
            fbun[i].tgt    = fb_tgt[i*PC_W +: PC_W];
        end
    end

    assign skid_head  = bundle_t'(skid_head_raw);
    assign any_stall  = rn_stall | ex_stall | cm_stall;
    assign f_live     = has_live(fbun);
    assign processing = (st == ST_IDLE) || (st == ST_RUN) || (st == ST_UNBLK);
    assign proc_en    = processing && !cm_squash && !any_stall &&
                        ((st == ST_UNBLK) ? !skid_empty : f_live);
    assign src        = (st == ST_UNBLK) ? skid_head : fbun;

    dec_skid_fifo #(.DW(BW), .DEPTH(SKID_DEPTH)) u_skid (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .clear (clr),
        .din   (BW'(fbun)),
        .head  (skid_head_raw),
        .empty (skid_empty),
        .full  (skid_full),
        .last  (skid_last)
    );

    dec_slot_proc u_proc (
        .en         (proc_en),
        .bin        (src),
        .lanes      (lanes),
        .redir      (p_redir),
        .redir_ctrl (p_ctrl),
        .redir_seq  (p_seq),
        .redir_npc  (p_npc)
    );

    always_comb begin
        nst  = st;
        push = 1'b0;
        pop  = 1'b0;
        clr  = 1'b0;
        unique case (st)
            ST_IDLE, ST_RUN, ST_UNBLK: begin
                if (cm_squash) begin
                    nst = ST_SQ;
                    clr = 1'b1;
                end else if (any_stall) begin
                    nst  = ST_BLK;
                    push = f_live;
                end else if (st == ST_UNBLK && skid_empty) begin
                    nst = ST_RUN;
                end else if (p_redir) begin
                    nst = ST_SQ;
                    clr = 1'b1;
                end else if (st == ST_UNBLK) begin
                    push = f_live;
                    pop  = 1'b1;
                    nst  = (skid_last && !f_live) ? ST_RUN : ST_UNBLK;
                end else begin
                    nst = f_live ? ST_RUN : ST_IDLE;
                end
            end
            ST_BLK: begin
                if (cm_squash || cm_rob_flush) begin
                    nst = ST_SQ;
                    clr = 1'b1;
                end else begin
                    push = f_live;
                    if (!any_stall)
                        nst = (skid_empty && !f_live) ? ST_RUN : ST_UNBLK;
                end
            end
            ST_SQ: begin
                if (!cm_squash && !cm_rob_flush) nst = ST_RUN;
                else if (cm_squash)              clr = 1'b1;
            end
            default: nst = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_IDLE;
            lanes_q       <= '0;
            fe_stall      <= 1'b0;
            fe_redir      <= 1'b0;
            fe_redir_ctrl <= 1'b0;
            fe_redir_seq  <= '0;
            fe_redir_npc  <= '0;
        end else begin
            st            <= nst;
            lanes_q       <= lanes;
            fe_stall      <= (nst == ST_BLK) || (nst == ST_UNBLK);
            fe_redir      <= p_redir;
            fe_redir_ctrl <= p_ctrl;
            fe_redir_seq  <= p_seq;
            fe_redir_npc  <= p_npc;
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            rn_vld[i]                  = lanes_q[i].vld;
            rn_rdy[i]                  = lanes_q[i].rdy;
            rn_seq[i*SEQ_W +: SEQ_W]   = lanes_q[i].seq;
            rn_pc[i*PC_W +: PC_W]      = lanes_q[i].pc;
            rn_npc[i*PC_W +: PC_W]     = lanes_q[i].npc;
        end
    end

    AST_SQUASH_EMPTIES_LANES: assert property (@(posedge clk) disable iff (rst)
        cm_squash |=> (rn_vld == '0)); // R2

    AST_HELD_NO_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BLK || st == ST_SQ) |=> (rn_vld == '0)); // R3

    AST_BLOCKED_STALLS_FETCH: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BLK) |-> fe_stall); // R4

    AST_UNBLK_HAS_WORK: assert property (@(posedge clk) disable iff (rst)
        (st == ST_UNBLK) |-> !skid_empty); // R6

    AST_REDIR_IN_SQUASH: assert property (@(posedge clk) disable iff (rst)
        fe_redir |-> (st == ST_SQ)); // R11

endmodule

// File: tb/decode_stage_tb.sv
module decode_stage_tb;
    import dec_pkg::*;

    logic                clk = 1'b0;
    logic                rst;
    logic [W-1:0]        fb_vld, fb_kill, fb_ptaken, fb_ctrl, fb_dub, fb_nosrc;
    logic [W*SEQ_W-1:0]  fb_seq;
    logic [W*PC_W-1:0]   fb_pc, fb_pnpc, fb_tgt;
    logic                rn_stall, ex_stall, cm_stall, cm_squash, cm_rob_flush;
    logic [W-1:0]        rn_vld, rn_rdy;
    logic [W*SEQ_W-1:0]  rn_seq;
    logic [W*PC_W-1:0]   rn_pc, rn_npc;
    logic                fe_stall, fe_redir, fe_redir_ctrl;
    logic [SEQ_W-1:0]    fe_redir_seq;
    logic [PC_W-1:0]     fe_redir_npc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    decode_stage u_dut (
        .clk(clk), .rst(rst),
        .fb_vld(fb_vld), .fb_kill(fb_kill), .fb_ptaken(fb_ptaken), .fb_ctrl(fb_ctrl),
        .fb_dub(fb_dub), .fb_nosrc(fb_nosrc), .fb_seq(fb_seq), .fb_pc(fb_pc),
        .fb_pnpc(fb_pnpc), .fb_tgt(fb_tgt),
        .rn_stall(rn_stall), .ex_stall(ex_stall), .cm_stall(cm_stall),
        .cm_squash(cm_squash), .cm_rob_flush(cm_rob_flush),
        .rn_vld(rn_vld), .rn_rdy(rn_rdy), .rn_seq(rn_seq), .rn_pc(rn_pc), .rn_npc(rn_npc),
        .fe_stall(fe_stall), .fe_redir(fe_redir), .fe_redir_ctrl(fe_redir_ctrl),
        .fe_redir_seq(fe_redir_seq), .fe_redir_npc(fe_redir_npc)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic clr_in();
        fb_vld = '0; fb_kill = '0; fb_ptaken = '0; fb_ctrl = '0; fb_dub = '0; fb_nosrc = '0;
        fb_seq = '0; fb_pc = '0; fb_pnpc = '0; fb_tgt = '0;
        rn_stall = 0; ex_stall = 0; cm_stall = 0; cm_squash = 0; cm_rob_flush = 0;
    endtask

    task automatic set_slot(input int i, input logic [SEQ_W-1:0] seq, input logic [PC_W-1:0] pc,
                            input logic [PC_W-1:0] pnpc, input logic [PC_W-1:0] tgt,
                            input logic ptk, input logic ctl, input logic dub);
        fb_vld[i] = 1'b1;
        fb_ptaken[i] = ptk; fb_ctrl[i] = ctl; fb_dub[i] = dub;
        fb_seq[i*SEQ_W +: SEQ_W] = seq;
        fb_pc[i*PC_W +: PC_W]    = pc;
        fb_pnpc[i*PC_W +: PC_W]  = pnpc;
        fb_tgt[i*PC_W +: PC_W]   = tgt;
    endtask

    // Full plain bundle with sequence numbers base..base+W-1
    task automatic plain_bundle(input logic [SEQ_W-1:0] base);
        fb_vld = '0;
        for (int i = 0; i < W; i++)
            set_slot(i, base + SEQ_W'(i), PC_W'(16'h2000 + 4 * i), '0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0]       ev, er;
        logic [W*SEQ_W-1:0] es;
        logic [W*PC_W-1:0]  ep, en;
        int                 lane;
        clr_in();
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;

        // R1: reset state
        chk("R1 rn_vld", 64'(rn_vld), 64'(0));
        chk("R1 fe_stall", 64'(fe_stall), 64'(0));
        chk("R1 fe_redir", 64'(fe_redir), 64'(0));
        plain_bundle(8'h10);
        cyc();
        chk("R1 first bundle", 64'(rn_vld), 64'({W{1'b1}}));

        // R8 R9 R10: sweep every valid mask and killed mask
        for (int m = 0; m < (1 << W); m++) begin
            for (int s = 0; s < (1 << W); s++) begin
                clr_in();
                ev = '0; er = '0; es = '0; ep = '0; en = '0; lane = 0;
                for (int i = 0; i < W; i++) begin
                    logic [SEQ_W-1:0] sq;
                    logic [PC_W-1:0]  pc, tg;
                    sq = SEQ_W'(16 * i + m);
                    pc = PC_W'(4096 + 64 * s + 4 * i);
                    tg = PC_W'(16'h8000 + m);
                    if (m[i]) begin
                        set_slot(i, sq, pc, tg, tg, i == 2, i == 2, i == 2);
                        fb_kill[i]  = s[i];
                        fb_nosrc[i] = i[0];
                    end
                    if (m[i] && !s[i]) begin
                        ev[lane] = 1'b1;
                        er[lane] = i[0];
                        es[lane*SEQ_W +: SEQ_W] = sq;
                        ep[lane*PC_W +: PC_W]   = pc;
                        en[lane*PC_W +: PC_W]   = (i == 2) ? tg : pc + PC_W'(4);
                        lane++;
                    end
                end
                cyc();
                chk("R8 lane valid", 64'(rn_vld), 64'(ev));
                chk("R8 lane seq", 64'(rn_seq), 64'(es));
                chk("R8 lane pc", 64'(rn_pc), 64'(ep));
                chk("R9 ready", 64'(rn_rdy), 64'(er));
                chk("R10 next pc", 64'(rn_npc), 64'(en));
            end
        end

        // R11: branch mispredict in slot 1
        clr_in();
        plain_bundle(8'h40);
        set_slot(1, 8'h41, 16'h3000, 16'h3004, 16'h3800, 1'b0, 1'b1, 1'b1);
        cyc();
        chk("R11 lanes up to branch", 64'(rn_vld), 64'(2'b11));
        chk("R11 redirect", 64'(fe_redir), 64'(1));
        chk("R11 redirect kind", 64'(fe_redir_ctrl), 64'(0));
        chk("R11 redirect seq", 64'(fe_redir_seq), 64'(8'h41));
        chk("R11 redirect pc", 64'(fe_redir_npc), 64'(16'h3800));
        clr_in();
        plain_bundle(8'h50);
        cyc();
        chk("R7 squashing ignores fetch", 64'(rn_vld), 64'(0));
        cyc();
        chk("R7 running after squash", 64'(rn_vld), 64'({W{1'b1}}));

        // R12: control mispredict in slot 0
        clr_in();
        plain_bundle(8'h60);
        set_slot(0, 8'h60, 16'h4000, 16'h4100, 16'h0, 1'b1, 1'b0, 1'b0);
        cyc();
        chk("R12 only offender forwarded", 64'(rn_vld), 64'(1));
        chk("R12 redirect kind", 64'(fe_redir_ctrl), 64'(1));
        chk("R12 redirect seq", 64'(fe_redir_seq), 64'(8'h60));
        chk("R12 redirect pc", 64'(fe_redir_npc), 64'(16'h4004));
        clr_in();
        cyc();

        // R3 R4 R5 R6: block, capture, unblock, replay with append
        clr_in();
        plain_bundle(8'h70); ex_stall = 1;
        cyc();
        chk("R3 no forward on stall", 64'(rn_vld), 64'(0));
        chk("R3 stall to fetch", 64'(fe_stall), 64'(1));
        clr_in();
        plain_bundle(8'h80); rn_stall = 1;
        cyc();
        chk("R4 blocked no forward", 64'(rn_vld), 64'(0));
        chk("R4 blocked stall", 64'(fe_stall), 64'(1));
        clr_in();
        cyc();
        chk("R5 unblock keeps stall", 64'(fe_stall), 64'(1));
        chk("R5 nothing forwarded", 64'(rn_vld), 64'(0));
        clr_in();
        plain_bundle(8'h90);
        cyc();
        chk("R6 oldest first", 64'(rn_seq[SEQ_W-1:0]), 64'(8'h70));
        chk("R6 stall during drain", 64'(fe_stall), 64'(1));
        clr_in();
        cyc();
        chk("R6 second bundle", 64'(rn_seq[SEQ_W-1:0]), 64'(8'h80));
        chk("R6 stall still high", 64'(fe_stall), 64'(1));
        cyc();
        chk("R6 appended bundle", 64'(rn_seq[SEQ_W-1:0]), 64'(8'h90));
        chk("R6 stall drops on last", 64'(fe_stall), 64'(0));
        plain_bundle(8'hA0);
        cyc();
        chk("R6 fetch path again", 64'(rn_seq[SEQ_W-1:0]), 64'(8'hA0));

        // R2: squash beats stall
        clr_in();
        plain_bundle(8'hB0); cm_stall = 1; cm_squash = 1;
        cyc();
        chk("R2 nothing forwarded", 64'(rn_vld), 64'(0));
        chk("R2 squash not block", 64'(fe_stall), 64'(0));
        clr_in();
        plain_bundle(8'hB8); cm_squash = 1;
        cyc();
        chk("R2 held while squash", 64'(rn_vld), 64'(0));
        clr_in();
        cyc();
        plain_bundle(8'hC0);
        cyc();
        chk("R7 resumes", 64'(rn_seq[SEQ_W-1:0]), 64'(8'hC0));

        // R7: reorder flush while blocked discards parked bundles
        clr_in();
        plain_bundle(8'hD0); rn_stall = 1;
        cyc();
        clr_in();
        cm_rob_flush = 1;
        cyc();
        chk("R7 flush leaves block", 64'(fe_stall), 64'(0));
        clr_in();
        cyc();
        cm_stall = 1;
        cyc();
        chk("R4 empty block stalls", 64'(fe_stall), 64'(1));
        clr_in();
        cyc();
        chk("R5 empty queue resumes", 64'(fe_stall), 64'(0));
        cyc();
        chk("R7 parked bundle discarded", 64'(rn_vld), 64'(0));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule